// File: doc/BRIEF.md
# Sigma-delta ADC control sequencer

This block is the digital control and status front end of a sigma-delta converter. Software reaches it over a simple 32-bit register bus. The bus writes with a one-cycle write strobe, and reads combinationally from the addressed word. The block holds the conversion configuration and the gain and offset trim words. It drives the analog enable, the input routing, the reference choice and the oversampling selection toward the modulator and filter. It also presents an LDO-ready status taken live from an input pin.

The block sequences conversions by handshaking with a decimator. While a conversion is wanted and the analog path is ready, it holds a run request high. The decimator answers each finished sample with a one-cycle done pulse and a 16-bit value. In single-shot mode one accepted sample ends the sequence. In continuous mode every accepted sample is stored until software clears the continuous bit, and the sequence then ends on the next sample. Each accepted sample raises a pending flag. The flag becomes an interrupt request only when the mask enable is set. When DMA is enabled, each accepted sample also gives a one-cycle DMA request.

Top module: `sdadc_ctrl`

## Requirements
- R1: After reset, every mapped register reads 0. With ldo_ready low, the control word at 0x00 also reads 0. irq, dma_req and dec_run are low.
- R2: The gain trim word sits at 0x0C and the offset trim word at 0x10. Each holds its low 10 bits, reads them back with zeros above, and drives gain_corr or offs_corr. Unmapped offsets such as 0x04 and 0x08 read 0.
- R3: A control write with bit 1 set while the start bit is 0 sets the start bit. dec_run is high exactly when start is 1, enable (bit 0) is 1 and ldo_ready is 1.
- R4: In single-shot mode (bit 12 = 0), an accepted done is a dec_done pulse while dec_run is high. One cycle after it, the start bit reads 0, the pending flag (bit 15) reads 1 and the result word at 0x18 holds the sample.
- R5: In continuous mode (bit 12 = 1), every accepted done stores its sample at 0x18 and leaves start at 1. After bit 12 is cleared, start stays 1 until the next accepted done and then returns to 0.
- R6: While start is 1, a control write neither clears start (bit 1 written 0) nor queues a further start (bit 1 written 1). The other fields of that write still take effect.
- R7: While enable or ldo_ready is 0, a set start bit is held. dec_run stays low and dec_done pulses neither change the result nor end the sequence. The conversion runs once both are 1.
- R8: The pending flag (bit 15) is read-only and is cleared by a write of any value to 0x14, which reads 0. A done accepted in the same cycle as that write leaves the flag set. A done accepted while the flag is set keeps it set.
- R9: irq is high exactly when the pending flag is 1 and the mask enable (bit 16) is 1. The pending flag is set regardless of the mask.
- R10: With DMA enable (bit 17) set, dma_req is high for exactly the one cycle after each accepted done. With bit 17 clear, dma_req stays low.
- R11: The positive select (bits 5:2) drives inp_sel and the negative select (bits 8:6) drives inn_sel. When the single-ended bit (bit 9) is 1 or the positive select is 8, inn_gnd is 1 and inn_sel is 0.
- R12: Enable (bit 0) drives mod_enable, bits 11:10 drive osr_sel and bit 13 drives vref_ext. Bit 14 reads the live ldo_ready, and a write to bit 14 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| ldo_ready | input | 1 | Analog supply ready |
| mod_enable | output | 1 | Enables the modulator path |
| inp_sel | output | 4 | Positive input select |
| inn_sel | output | 3 | Negative input select, 0 when grounded |
| inn_gnd | output | 1 | Negative side tied to ground |
| single_ended | output | 1 | Single-ended conversion |
| vref_ext | output | 1 | External reference selected |
| osr_sel | output | 2 | Oversampling ratio code |
| gain_corr | output | 10 | Gain trim to the filter |
| offs_corr | output | 10 | Offset trim to the filter |
| dec_run | output | 1 | Conversion request to the decimator |
| dec_done | input | 1 | One-cycle sample-ready pulse |
| dec_sample | input | 16 | Sample value, valid with dec_done |
| irq | output | 1 | Masked interrupt request |
| dma_req | output | 1 | One-cycle DMA request per new result |

## Verification
The bench targets the places where the sequence can end at the wrong time. It clears the continuous bit while a sample is in progress; a design that stopped at once would drop start before the last sample arrived. It rewrites start while a conversion runs; a design that queued the request would restart after the sample. It pulses dec_done while enable or ldo_ready is low; a design that did not gate the handshake would store a stray result. It lands a clear-interrupt write on the same cycle as a done; a design with the wrong priority would lose the new event. A cycle-by-cycle reference model also catches routing mistakes, such as inn_sel left live in single-ended mode or on the battery channel, and a DMA pulse lasting longer than a cycle.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  // Register byte offsets
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_GAIN  = 'h0C;
  localparam int unsigned OFS_OFFS  = 'h10;
  localparam int unsigned OFS_CLR   = 'h14;
  localparam int unsigned OFS_RES   = 'h18;

  // Control word field positions
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_START   = 1;
  localparam int unsigned B_INP_LO  = 2;
  localparam int unsigned INP_W     = 4;
  localparam int unsigned B_INN_LO  = 6;
  localparam int unsigned INN_W     = 3;
  localparam int unsigned B_SE      = 9;
  localparam int unsigned B_OSR_LO  = 10;
  localparam int unsigned OSR_W     = 2;
  localparam int unsigned B_CONT    = 12;
  localparam int unsigned B_VREF    = 13;
  localparam int unsigned B_LDO     = 14;
  localparam int unsigned B_PEND    = 15;
  localparam int unsigned B_MASK    = 16;
  localparam int unsigned B_DMA     = 17;

  // Positive-select code of the battery channel
  localparam int unsigned VBAT_CODE = 8;

  typedef struct packed {
    logic             dma_en;
    logic             mask;
    logic             vref_ext;
    logic             cont;
    logic [OSR_W-1:0] osr;
    logic             se;
    logic [INN_W-1:0] inn;
    logic [INP_W-1:0] inp;
    logic             en;
  } ctrl_cfg_t;

endpackage

// File: rtl/sdadc_regs.sv
module sdadc_regs
  import sdadc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CORR_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                ldo_ready,
  input  logic                start_q,
  input  logic                pend_q,
  input  logic [SAMPLE_W-1:0] result_q,
  output logic                wr_ctrl,
  output logic                wr_clr,
  output ctrl_cfg_t           cfg_q,
  output logic [CORR_W-1:0]   gain_q,
  output logic [CORR_W-1:0]   offs_q
);

  ctrl_cfg_t         cfg_d;
  logic [CORR_W-1:0] gain_d;
  logic [CORR_W-1:0] offs_d;
  logic              wr_gain;
  logic              wr_offs;
  logic              unused_wdata;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_gain = bus_we && (bus_addr == ADDR_W'(OFS_GAIN));
  assign wr_offs = bus_we && (bus_addr == ADDR_W'(OFS_OFFS));
  assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));

  // Bits owned by other logic or not implemented
  assign unused_wdata = ^{bus_wdata[DATA_W-1:B_DMA+1], bus_wdata[B_PEND],
                          bus_wdata[B_LDO], bus_wdata[B_START]};

  // Next-state values
  always_comb begin
    cfg_d.en       = bus_wdata[B_EN];
    cfg_d.inp      = bus_wdata[B_INP_LO +: INP_W];
    cfg_d.inn      = bus_wdata[B_INN_LO +: INN_W];
    cfg_d.se       = bus_wdata[B_SE];
    cfg_d.osr      = bus_wdata[B_OSR_LO +: OSR_W];
    cfg_d.cont     = bus_wdata[B_CONT];
    cfg_d.vref_ext = bus_wdata[B_VREF];
    cfg_d.mask     = bus_wdata[B_MASK];
    cfg_d.dma_en   = bus_wdata[B_DMA];
    gain_d         = bus_wdata[CORR_W-1:0];
    offs_d         = bus_wdata[CORR_W-1:0];
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ctrl) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
    end else if (wr_gain) begin
      gain_q <= gain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
    end else if (wr_offs) begin
      offs_q <= offs_d;
    end
  end

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[B_EN]               = cfg_q.en;
        bus_rdata[B_START]            = start_q;
        bus_rdata[B_INP_LO +: INP_W]  = cfg_q.inp;
        bus_rdata[B_INN_LO +: INN_W]  = cfg_q.inn;
        bus_rdata[B_SE]               = cfg_q.se;
        bus_rdata[B_OSR_LO +: OSR_W]  = cfg_q.osr;
        bus_rdata[B_CONT]             = cfg_q.cont;
        bus_rdata[B_VREF]             = cfg_q.vref_ext;
        bus_rdata[B_LDO]              = ldo_ready;
        bus_rdata[B_PEND]             = pend_q;
        bus_rdata[B_MASK]             = cfg_q.mask;
        bus_rdata[B_DMA]              = cfg_q.dma_en;
      end
      ADDR_W'(OFS_GAIN): bus_rdata[CORR_W-1:0]   = gain_q;
      ADDR_W'(OFS_OFFS): bus_rdata[CORR_W-1:0]   = offs_q;
      ADDR_W'(OFS_RES):  bus_rdata[SAMPLE_W-1:0] = result_q;
      default:           bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sdadc_seq.sv
module sdadc_seq #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                cont,
  input  logic                dma_en,
  input  logic                ldo_ready,
  input  logic                set_start_req,
  input  logic                clr_pend_req,
  input  logic                dec_done,
  input  logic [SAMPLE_W-1:0] dec_sample,
  output logic                dec_run,
  output logic                start_q,
  output logic                pend_q,
  output logic [SAMPLE_W-1:0] result_q,
  output logic                dma_q
);

  logic                start_d;
  logic                pend_d;
  logic                dma_d;
  logic                done_acc;
  logic [SAMPLE_W-1:0] result_d;

  // A run is requested only with a live start and a ready analog path
  assign dec_run  = start_q && en && ldo_ready;
  assign done_acc = dec_done && dec_run;

  always_comb begin
    start_d = start_q;
    if (done_acc && !cont) begin
      start_d = 1'b0;
    end else if (set_start_req && !start_q) begin
      start_d = 1'b1;
    end

    pend_d = pend_q;
    if (done_acc) begin
      pend_d = 1'b1;
    end else if (clr_pend_req) begin
      pend_d = 1'b0;
    end

    result_d = dec_sample;
    dma_d    = done_acc && dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      pend_q  <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      pend_q  <= pend_d;
      dma_q   <= dma_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (done_acc) begin
      result_q <= result_d;
    end
  end

endmodule

// File: rtl/sdadc_route.sv
module sdadc_route
  import sdadc_pkg::*;
(
  input  ctrl_cfg_t        cfg,
  output logic [INP_W-1:0] inp_sel,
  output logic [INN_W-1:0] inn_sel,
  output logic             inn_gnd,
  output logic             single_ended
);

  logic vbat_sel;

  assign vbat_sel     = (cfg.inp == INP_W'(VBAT_CODE));
  assign inp_sel      = cfg.inp;
  assign single_ended = cfg.se;
  assign inn_gnd      = cfg.se || vbat_sel;
  assign inn_sel      = inn_gnd ? '0 : cfg.inn;

endmodule

// File: rtl/sdadc_ctrl.sv
module sdadc_ctrl
  import sdadc_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned CORR_W     = 10,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                ldo_ready,
  output logic                mod_enable,
  output logic [INP_W-1:0]    inp_sel,
  output logic [INN_W-1:0]    inn_sel,
  output logic                inn_gnd,
  output logic                single_ended,
  output logic                vref_ext,
  output logic [OSR_W-1:0]    osr_sel,
  output logic [CORR_W-1:0]   gain_corr,
  output logic [CORR_W-1:0]   offs_corr,
  output logic                dec_run,
  input  logic                dec_done,
  input  logic [SAMPLE_W-1:0] dec_sample,
  output logic                irq,
  output logic                dma_req
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;
  ctrl_cfg_t             cfg;
  logic                  cfg_cont;
  logic                  wr_ctrl;
  logic                  wr_clr;
  logic                  start_q;
  logic                  pend_q;
  logic [SAMPLE_W-1:0]   result_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  sdadc_regs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SAMPLE_W(SAMPLE_W),
    .CORR_W  (CORR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ldo_ready(ldo_ready),
    .start_q  (start_q),
    .pend_q   (pend_q),
    .result_q (result_q),
    .wr_ctrl  (wr_ctrl),
    .wr_clr   (wr_clr),
    .cfg_q    (cfg),
    .gain_q   (gain_corr),
    .offs_q   (offs_corr)
  );

  sdadc_seq #(
    .SAMPLE_W(SAMPLE_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .en           (cfg.en),
    .cont         (cfg.cont),
    .dma_en       (cfg.dma_en),
    .ldo_ready    (ldo_ready),
    .set_start_req(wr_ctrl && bus_wdata[B_START]),
    .clr_pend_req (wr_clr),
    .dec_done     (dec_done),
    .dec_sample   (dec_sample),
    .dec_run      (dec_run),
    .start_q      (start_q),
    .pend_q       (pend_q),
    .result_q     (result_q),
    .dma_q        (dma_req)
  );

  sdadc_route u_route (
    .cfg         (cfg),
    .inp_sel     (inp_sel),
    .inn_sel     (inn_sel),
    .inn_gnd     (inn_gnd),
    .single_ended(single_ended)
  );

  assign cfg_cont   = cfg.cont;
  assign mod_enable = cfg.en;
  assign vref_ext   = cfg.vref_ext;
  assign osr_sel    = cfg.osr;
  assign irq        = pend_q && cfg.mask;

endmodule

// File: rtl/sdadc_ctrl_chk.sv
module sdadc_ctrl_chk #(
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic                dec_done,
  input logic                dec_run,
  input logic [SAMPLE_W-1:0] dec_sample,
  input logic                cfg_cont,
  input logic                start_q,
  input logic                pend_q,
  input logic [SAMPLE_W-1:0] result_q,
  input logic                irq,
  input logic                dma_req,
  input logic                mod_enable,
  input logic                ldo_ready,
  input logic [3:0]          inp_sel,
  input logic [2:0]          inn_sel,
  input logic                inn_gnd
);

  assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> pend_q);

  assert_single_ends_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_done && dec_run && !cfg_cont) |=> (!start_q && pend_q));

  assert_result_capture_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_done && dec_run) |=> (result_q == $past(dec_sample)));

  assert_cont_keeps_start_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_done && dec_run && cfg_cont) |=> start_q);

  assert_start_held_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start_q && !(dec_done && dec_run)) |=> start_q);

  assert_run_gated_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    dec_run |-> (mod_enable && ldo_ready && start_q));

  assert_result_quiet_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(dec_done && dec_run) |=> $stable(result_q));

  assert_dma_source_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    dma_req |-> $past(dec_done && dec_run));

  assert_vbat_ground_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (inp_sel == 4'd8) |-> (inn_gnd && (inn_sel == 3'd0)));

endmodule

bind sdadc_ctrl sdadc_ctrl_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .dec_done  (dec_done),
  .dec_run   (dec_run),
  .dec_sample(dec_sample),
  .cfg_cont  (cfg_cont),
  .start_q   (start_q),
  .pend_q    (pend_q),
  .result_q  (result_q),
  .irq       (irq),
  .dma_req   (dma_req),
  .mod_enable(mod_enable),
  .ldo_ready (ldo_ready),
  .inp_sel   (inp_sel),
  .inn_sel   (inn_sel),
  .inn_gnd   (inn_gnd)
);

// File: tb/tb_sdadc_ctrl.sv
`timescale 1ns/1ps
module tb_sdadc_ctrl;

  localparam int WD_LIMIT = 20000;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ldo_ready;
  logic        mod_enable;
  logic [3:0]  inp_sel;
  logic [2:0]  inn_sel;
  logic        inn_gnd;
  logic        single_ended;
  logic        vref_ext;
  logic [1:0]  osr_sel;
  logic [9:0]  gain_corr;
  logic [9:0]  offs_corr;
  logic        dec_run;
  logic        dec_done;
  logic [15:0] dec_sample;
  logic        irq;
  logic        dma_req;

  sdadc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ldo_ready(ldo_ready),
    .mod_enable(mod_enable), .inp_sel(inp_sel), .inn_sel(inn_sel),
    .inn_gnd(inn_gnd), .single_ended(single_ended), .vref_ext(vref_ext),
    .osr_sel(osr_sel), .gain_corr(gain_corr), .offs_corr(offs_corr),
    .dec_run(dec_run), .dec_done(dec_done), .dec_sample(dec_sample),
    .irq(irq), .dma_req(dma_req)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 0;
  bit chk_on = 0;
  int cyc = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Behavioural reference model
  bit        m_en, m_start, m_se, m_cont, m_vref, m_pend, m_mask, m_dma, m_dmaq;
  bit [3:0]  m_inp;
  bit [2:0]  m_inn;
  bit [1:0]  m_osr;
  bit [9:0]  m_gain, m_offs;
  bit [15:0] m_res;

  function automatic logic [31:0] m_ctrl();
    return {14'd0, m_dma, m_mask, m_pend, ldo_ready, m_vref, m_cont,
            m_osr, m_se, m_inn, m_inp, m_start, m_en};
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_ctrl();
      5'h0C:   return {22'd0, m_gain};
      5'h10:   return {22'd0, m_offs};
      5'h18:   return {16'd0, m_res};
      default: return 32'd0;
    endcase
  endfunction

  bit acc, n_start, n_pend, n_dmaq, gnd;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {m_en, m_start, m_se, m_cont, m_vref, m_pend, m_mask, m_dma, m_dmaq} = '0;
      m_inp = 0; m_inn = 0; m_osr = 0; m_gain = 0; m_offs = 0; m_res = 0;
    end else begin
      acc     = dec_done && m_start && m_en && ldo_ready;
      n_start = m_start;
      if (acc && !m_cont) n_start = 0;
      else if (bus_we && bus_addr == 5'h00 && bus_wdata[1] && !m_start) n_start = 1;
      n_pend = acc ? 1'b1 : ((bus_we && bus_addr == 5'h14) ? 1'b0 : m_pend);
      n_dmaq = acc && m_dma;
      if (acc) m_res = dec_sample;
      if (bus_we && bus_addr == 5'h00) begin
        m_en = bus_wdata[0]; m_inp = bus_wdata[5:2]; m_inn = bus_wdata[8:6];
        m_se = bus_wdata[9]; m_osr = bus_wdata[11:10]; m_cont = bus_wdata[12];
        m_vref = bus_wdata[13]; m_mask = bus_wdata[16]; m_dma = bus_wdata[17];
      end
      if (bus_we && bus_addr == 5'h0C) m_gain = bus_wdata[9:0];
      if (bus_we && bus_addr == 5'h10) m_offs = bus_wdata[9:0];
      m_start = n_start; m_pend = n_pend; m_dmaq = n_dmaq;
    end
    #1;
    if (chk_on) begin
      gnd = m_se || (m_inp == 4'd8);
      check("R3", "model dec_run", dec_run, m_start && m_en && ldo_ready);
      check("R9", "model irq", irq, m_pend && m_mask);
      check("R10", "model dma_req", dma_req, m_dmaq);
      check("R11", "model routing", {inp_sel, inn_sel, inn_gnd, single_ended},
            {m_inp, gnd ? 3'd0 : m_inn, gnd, m_se});
      check("R12", "model analog", {mod_enable, osr_sel, vref_ext}, {m_en, m_osr, m_vref});
      check("R2", "model trims", {gain_corr, offs_corr}, {m_gain, m_offs});
      check("R2", "model rdata", bus_rdata, m_read(bus_addr));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > WD_LIMIT && !done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic [15:0] s);
    @(negedge clk);
    dec_done = 1; dec_sample = s;
    @(negedge clk);
    dec_done = 0;
  endtask

  // Control word bits used by the bench (from the requirements)
  localparam logic [31:0] C_EN   = 32'h1;
  localparam logic [31:0] C_ST   = 32'h2;
  localparam logic [31:0] C_SE   = 32'h200;
  localparam logic [31:0] C_CONT = 32'h1000;
  localparam logic [31:0] C_VREF = 32'h2000;
  localparam logic [31:0] C_LDO  = 32'h4000;
  localparam logic [31:0] C_PEND = 32'h8000;
  localparam logic [31:0] C_MASK = 32'h10000;
  localparam logic [31:0] C_DMA  = 32'h20000;

  logic [31:0] v;

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    ldo_ready = 0; dec_done = 0; dec_sample = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    // R1 reset values
    foreach (v[i]) ; // no-op keeps loop var scoping simple
    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], v);
      check("R1", "reset read", v, 32'd0);
    end
    check("R1", "reset irq/dma/run", {irq, dma_req, dec_run}, 3'b000);

    // R2 trims and unmapped offsets
    wr(5'h0C, 32'hFFFF_F2A5);
    wr(5'h10, 32'h0000_0133);
    rd(5'h0C, v); check("R2", "gain read", v, 32'h2A5);
    rd(5'h10, v); check("R2", "offs read", v, 32'h133);
    check("R2", "trim outputs", {gain_corr, offs_corr}, {10'h2A5, 10'h133});
    rd(5'h04, v); check("R2", "unmapped 0x04", v, 0);
    rd(5'h08, v); check("R2", "unmapped 0x08", v, 0);

    // R11/R12 routing and analog outputs; bit 14 write ignored
    wr(5'h00, C_EN | (32'd3 << 2) | (32'd5 << 6) | (32'd2 << 10) | C_VREF | C_LDO);
    check("R11", "diff routing", {inp_sel, inn_sel, inn_gnd, single_ended}, {4'd3, 3'd5, 1'b0, 1'b0});
    check("R12", "analog outs", {mod_enable, osr_sel, vref_ext}, {1'b1, 2'd2, 1'b1});
    rd(5'h00, v); check("R12", "ldo bit ignores write", v & C_LDO, 0);
    ldo_ready = 1;
    rd(5'h00, v); check("R12", "ldo bit live", v & C_LDO, C_LDO);
    wr(5'h00, C_EN | (32'd3 << 2) | (32'd5 << 6) | C_SE);
    check("R11", "single-ended routing", {inn_sel, inn_gnd, single_ended}, {3'd0, 1'b1, 1'b1});
    wr(5'h00, C_EN | (32'd8 << 2) | (32'd6 << 6));
    check("R11", "battery routing", {inp_sel, inn_sel, inn_gnd}, {4'd8, 3'd0, 1'b1});

    // R3/R4/R9/R10 single shot
    wr(5'h00, C_EN | C_MASK | C_DMA | C_ST);
    check("R3", "run after start", dec_run, 1);
    done_pulse(16'h1234);
    check("R10", "dma pulse", dma_req, 1);
    check("R9", "irq raised", irq, 1);
    rd(5'h00, v); check("R4", "start cleared, pending set", v & (C_ST | C_PEND), C_PEND);
    check("R10", "dma one cycle", dma_req, 0);
    rd(5'h18, v); check("R4", "result", v, 32'h1234);

    // R8 clear
    wr(5'h14, 32'hDEAD_0000);
    rd(5'h00, v); check("R8", "pending cleared", v & C_PEND, 0);
    rd(5'h14, v); check("R8", "clear reg reads 0", v, 0);

    // R9 masked: pending without irq; DMA off -> no pulse
    wr(5'h00, C_EN | C_ST);
    done_pulse(16'h00AA);
    check("R10", "no dma when disabled", dma_req, 0);
    check("R9", "irq masked", irq, 0);
    rd(5'h00, v); check("R9", "pending despite mask", v & C_PEND, C_PEND);
    // R8 done while pending keeps flag
    wr(5'h00, C_EN | C_ST);
    done_pulse(16'h00AB);
    rd(5'h00, v); check("R8", "stays pending", v & C_PEND, C_PEND);

    // R8 clear and done in the same cycle
    wr(5'h00, C_EN | C_ST);
    @(negedge clk);
    bus_we = 1; bus_addr = 5'h14; bus_wdata = 0; dec_done = 1; dec_sample = 16'h0777;
    @(negedge clk);
    bus_we = 0; dec_done = 0;
    rd(5'h00, v); check("R8", "set wins over clear", v & C_PEND, C_PEND);
    wr(5'h14, 0);

    // R5/R6 continuous
    wr(5'h00, C_EN | C_CONT | C_ST);
    for (int k = 0; k < 3; k++) begin
      done_pulse(16'hA000 + 16'(k));
      rd(5'h18, v); check("R5", "cont result", v, 32'hA000 + k);
      rd(5'h00, v); check("R5", "cont start held", v & C_ST, C_ST);
    end
    wr(5'h00, C_EN | C_CONT);
    rd(5'h00, v); check("R6", "write 0 keeps start", v & C_ST, C_ST);
    wr(5'h00, C_EN | C_ST | (32'd2 << 2));
    rd(5'h00, v); check("R5", "start held after cont cleared", v & C_ST, C_ST);
    check("R6", "other fields of write apply", inp_sel, 4'd2);
    done_pulse(16'h5555);
    rd(5'h00, v); check("R5", "start drops on last sample", v & C_ST, 0);
    check("R6", "no queued restart", dec_run, 0);
    rd(5'h18, v); check("R5", "last sample kept", v, 32'h5555);

    // R7 hold-off
    ldo_ready = 0;
    wr(5'h00, C_EN | C_ST);
    check("R7", "no run without ldo", dec_run, 0);
    done_pulse(16'hBEEF);
    rd(5'h18, v); check("R7", "stray done ignored", v, 32'h5555);
    rd(5'h00, v); check("R7", "start held", v & C_ST, C_ST);
    wr(5'h00, C_ST);
    ldo_ready = 1;
    #0.5;
    check("R7", "no run without enable", dec_run, 0);
    wr(5'h00, C_EN);
    check("R7", "run once ready", dec_run, 1);
    done_pulse(16'h0BAD);
    rd(5'h18, v); check("R7", "held conversion completes", v, 32'h0BAD);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule